// File: doc/BRIEF.md
# Dual-Edge Binary Counter

This block is an up-counter that advances once on every rising edge and once on every falling edge of a single clock. It is built only from ordinary flip-flops that each respond to one edge polarity, so it can be used in libraries that have no double-edge cells. The state sits in two registers of equal width. One register updates on the rising edge and the other updates on the falling edge. The visible count is the bitwise XOR of the two registers, and neither register holds the count value on its own.

The increment is always taken from the XOR result. The register being updated loads the incremented value XORed with the contents of the opposite register, so the XOR of the pair equals the new count once the edge has passed. An active-low asynchronous reset clears both registers. An optional enable, built in when the `HAS_ENABLE` parameter is set, can freeze the counter on any edge. `WIDTH` sets the counter width.

Top module: `dual_edge_counter`

## Requirements
- R1: While `rst_n` is low the count output is zero, and asserting `rst_n` clears the count without waiting for a clock edge.
- R2: On each rising edge of `clk` where `en` is high (HAS_ENABLE=1), the count becomes the previous count plus one, modulo 2^WIDTH.
- R3: On each falling edge of `clk` where `en` is high (HAS_ENABLE=1), the count becomes the previous count plus one, modulo 2^WIDTH.
- R4: A count of all ones (2^WIDTH-1) that is incremented at an edge of either polarity becomes zero.
- R5: With HAS_ENABLE=1, an edge of either polarity at which `en` is low leaves the count unchanged.
- R6: With HAS_ENABLE=0, the `en` input is ignored and the count increments at every clock edge of both polarities.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Both edges advance the count |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable, sampled at each edge. Ignored when HAS_ENABLE=0 |
| count | output | WIDTH | XOR of the rising-edge and falling-edge registers |

## Verification
The bench builds two instances. The first uses WIDTH=4 with the enable present. Its 16-value range wraps within eight clock periods, so the all-ones to zero step is reached many times on both edge polarities. Random enable patterns also freeze the counter across mixed rising and falling edges. The second uses WIDTH=3 with the enable removed. It is driven with the same random `en` to show that the input has no effect, and it wraps every four clock periods.

// File: rtl/dec_pkg.sv
package dec_pkg;

   // Edge polarity that a half register responds to
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_e;

endpackage

// File: rtl/dec_incr.sv
// Ripple-carry incrementer; the step input feeds the carry-in so a low
// step passes the value through unchanged.
module dec_incr #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             step,
   output logic [WIDTH-1:0] nxt
);
   localparam int NCARRY = WIDTH + 1;

   logic [NCARRY-1:0] carry;

   assign carry[0] = step;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign nxt[i]     = cur[i] ^ carry[i];
      assign carry[i+1] = cur[i] & carry[i];
   end

   // The carry out of the top bit is dropped so the count wraps
   logic unused_carry_out;
   assign unused_carry_out = carry[NCARRY-1];

endmodule

// File: rtl/dec_half_reg.sv
// One half of the split state: a register triggered on a single edge
// polarity. It loads the target count XORed with the opposite half, so
// the XOR of both halves equals the target after the edge.
module dec_half_reg
   import dec_pkg::*;
#(
   parameter int    WIDTH = 16,
   parameter edge_e EDGE  = EDGE_RISE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] target,
   input  logic [WIDTH-1:0] other,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] load_val;

   assign load_val = target ^ other;

   if (EDGE == EDGE_RISE) begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= load_val;
      end
   end else begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= load_val;
      end
   end

endmodule

// File: rtl/dual_edge_counter.sv
// Counter that advances on both clock edges using single-edge flops.
module dual_edge_counter
   import dec_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter bit HAS_ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [WIDTH-1:0] count
);
   localparam int MAX_WIDTH = 64;

   if (WIDTH < 1 || WIDTH > MAX_WIDTH) begin : g_bad_width
      $error("dual_edge_counter: WIDTH must lie in 1..64");
   end

   logic [WIDTH-1:0] q_rise;
   logic [WIDTH-1:0] q_fall;
   logic [WIDTH-1:0] count_nxt;
   logic             step;

   // The step is gated by en only in the variant that has an enable
   if (HAS_ENABLE) begin : g_en
      assign step = en;
   end else begin : g_free
      logic unused_en;
      assign unused_en = en;
      assign step      = 1'b1;
   end

   // True count: neither half is meaningful on its own
   assign count = q_rise ^ q_fall;

   dec_incr #(
      .WIDTH (WIDTH)
   ) u_incr (
      .cur  (count),
      .step (step),
      .nxt  (count_nxt)
   );

   dec_half_reg #(
      .WIDTH (WIDTH),
      .EDGE  (EDGE_RISE)
   ) u_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .target (count_nxt),
      .other  (q_fall),
      .q      (q_rise)
   );

   dec_half_reg #(
      .WIDTH (WIDTH),
      .EDGE  (EDGE_FALL)
   ) u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .target (count_nxt),
      .other  (q_rise),
      .q      (q_fall)
   );

endmodule

// File: rtl/dec_checker.sv
// Each edge records the count it saw and the enable. The opposite edge,
// which comes next, checks the result of that update.
module dec_checker #(
   parameter int WIDTH      = 16,
   parameter bit HAS_ENABLE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [WIDTH-1:0] count
);
   logic             step;
   logic [WIDTH-1:0] r_prev, f_prev;
   logic             r_step, f_step, r_en, f_en, r_seen, f_seen;

   assign step = en | !HAS_ENABLE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_prev <= '0; r_step <= 1'b0; r_en <= 1'b0; r_seen <= 1'b0;
      end else begin
         r_prev <= count; r_step <= step; r_en <= en; r_seen <= 1'b1;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_prev <= '0; f_step <= 1'b0; f_en <= 1'b0; f_seen <= 1'b0;
      end else begin
         f_prev <= count; f_step <= step; f_en <= en; f_seen <= 1'b1;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |-> count == '0);

   assert_rise_inc_R2: assert property (@(negedge clk) disable iff (!rst_n)
      (r_seen && r_step) |-> count == WIDTH'(r_prev + 1'b1));

   assert_fall_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (f_seen && f_step) |-> count == WIDTH'(f_prev + 1'b1));

   assert_wrap_R4: assert property (@(negedge clk) disable iff (!rst_n)
      (r_seen && r_step && r_prev == '1) |-> count == '0);

   assert_hold_rise_R5: assert property (@(negedge clk) disable iff (!rst_n)
      (r_seen && !r_step) |-> count == r_prev);

   assert_hold_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (f_seen && !f_step) |-> count == f_prev);

   assert_ignore_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!HAS_ENABLE && f_seen && !f_en) |-> count == WIDTH'(f_prev + 1'b1));

endmodule

bind dual_edge_counter dec_checker #(
   .WIDTH      (WIDTH),
   .HAS_ENABLE (HAS_ENABLE)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .en    (en),
   .count (count)
);

// File: tb/dual_edge_counter_tb.sv
module dual_edge_counter_tb;
   localparam int W_A = 4;
   localparam int W_B = 3;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           en;
   logic [W_A-1:0] cnt_a;
   logic [W_B-1:0] cnt_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   int exp_a, exp_b;

   always #4 clk = ~clk;   // 125 MHz

   dual_edge_counter #(.WIDTH(W_A), .HAS_ENABLE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .count(cnt_a));

   dual_edge_counter #(.WIDTH(W_B), .HAS_ENABLE(1'b0)) u_dut_free (
      .clk(clk), .rst_n(rst_n), .en(en), .count(cnt_b));

   function automatic int next_val(input int cur, input bit stp, input int w);
      return (cur + (stp ? 1 : 0)) % (1 << w);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: count=%0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Set en 1 ns after an edge, then check 1 ns after the next edge
   task automatic half_step(input bit en_v);
      bit was_top;
      was_top = (exp_a == (1 << W_A) - 1);
      en = en_v;
      @(clk);
      #1;
      exp_a = next_val(exp_a, en_v, W_A);
      exp_b = next_val(exp_b, 1'b1, W_B);
      if (!en_v)        chk("R5", int'(cnt_a), exp_a);
      else if (was_top) chk("R4", int'(cnt_a), exp_a);
      else if (clk)     chk("R2", int'(cnt_a), exp_a);
      else              chk("R3", int'(cnt_a), exp_a);
      if (!en_v) chk("R6", int'(cnt_b), exp_b);
      else       chk(clk ? "R2" : "R3", int'(cnt_b), exp_b);
   endtask

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0;
      en    = 1'b0;
      #10;
      chk("R1", int'(cnt_a), 0);
      chk("R1", int'(cnt_b), 0);
      #12 rst_n = 1'b1;   // released away from any edge
      exp_a = 0; exp_b = 0;
      // Directed run: wrap both counters several times
      for (int i = 0; i < 40; i++) half_step(1'b1);
      // Directed freeze across both edge polarities
      for (int i = 0; i < 6; i++) half_step(1'b0);
      // Random enable patterns
      for (int i = 0; i < 600; i++) half_step(($urandom % 4) != 0);
      // Asynchronous reset between edges
      rst_n = 1'b0;
      #1;
      chk("R1", int'(cnt_a), 0);
      chk("R1", int'(cnt_b), 0);
      #1 rst_n = 1'b1;
      exp_a = 0; exp_b = 0;
      for (int i = 0; i < 36; i++) half_step(1'b1);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule